// File: doc/BRIEF.md
# SPI serial EEPROM command engine

This block is the serial slave front end of a 256-byte nonvolatile memory. Chip select, serial clock, serial data in and an active-low pause input are brought into the system clock domain through synchronizers. The block shifts in an 8-bit command and then address and data bytes, most significant bit first. It serves sequential reads from a register array, returns a status byte, and keeps a write-enable latch. Data for a page write is gathered in a small page buffer.

Serial input is taken on the falling clock edge, and the output bit changes after the rising edge. A write is handed to a separate write controller as a one-cycle commit request. The request carries the page base, a byte-valid mask and the page data. It is raised only when chip select is released exactly on a byte boundary. The write controller owns the self-timed cycle and the block protection. It reports back through a busy input and a done pulse, and that pulse writes the masked bytes into the array. The serial output has a separate enable, so it can be tri-stated at the pad.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset nothing is accepted until chip select has been seen high and then falls. A command clocked while chip select has stayed low since reset is ignored, and `miso_oe` stays low.
- R2: Command 0x06 sets the write-enable latch and 0x04 clears it. Status bit 1 shows the latch.
- R3: Command 0x05 returns the status byte {4'b0000, prot_level[1:0], latch, 1'b0}, with protection in bits 3:2. While `nv_busy` is high the status byte reads 0xFF. Its MSB appears after the first rising clock edge that follows the last command bit.
- R4: Command 0x03 followed by an address returns data from that address. The address increments after each byte and wraps from 0xFF to 0x00.
- R5: Command 0x02 followed by an address collects data bytes. Each byte lands in the lane given by the low two address bits, and the lane wraps within the 4-byte page, so a fifth byte overwrites the first. The commit carries the page base (low two bits zero), a mask with bit n set for each written lane n, and lane n in `commit_data[8n+7:8n]`.
- R6: `commit_req` pulses for one cycle only when three conditions hold: the latch is set, at least one whole data byte has arrived, and chip select rises with no partial byte pending. In every other case the write is dropped.
- R7: Command 0x01 followed by one byte commits with `commit_is_status` high, mask 4'b0001 and that byte in lane 0. On completion the write controller loads bits 3:2 into `prot_level`.
- R8: While `nv_busy` is high, every command except 0x05 is ignored: no commit, no latch change, and a read returns 0x00.
- R9: Pulling `hold_n` low while the serial clock is high pauses the transfer. Clock edges are then ignored and `miso_oe` is low. Releasing it while the clock is high resumes at the same bit.
- R10: `miso_oe` is high only while selected and not paused.
- R11: `commit_done` writes only the masked bytes of the pending array commit into the array and clears the latch. Cells never written read 0xFF after reset.
- R12: Chip select going high resets the bit and byte counters and drops a partial command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the serial data out pad |
| nv_busy | input | 1 | Write controller busy with a write cycle |
| prot_level | input | 2 | Protection level held by the write controller |
| commit_done | input | 1 | One-cycle pulse when the write cycle finishes |
| commit_req | output | 1 | One-cycle write commit request |
| commit_is_status | output | 1 | Commit is a status write rather than an array write |
| commit_base | output | ADDR_W | Page base address of the commit |
| commit_mask | output | PAGE_BYTES | Byte-valid mask per page lane |
| commit_data | output | 8*PAGE_BYTES | Page data, lane n in bits 8n+7:8n |

## Verification
The bench goes after commit timing. It releases chip select three bits into a data byte, after the address with no data at all, and with the latch clear; a design that counts clocks loosely would commit a torn or empty page. A five-byte page write starting mid-page checks that the lane wraps inside the page, and a read from 0xFE checks that the address wraps over the whole array. While busy it sends a read and a write, so a design that does not gate commands would return array data or raise a second commit. A pause in the middle of a byte, with clock edges during the pause, shows whether the design miscounts bits.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
   localparam logic [7:0] OP_SET_WEN = 8'h06;
   localparam logic [7:0] OP_CLR_WEN = 8'h04;
   localparam logic [7:0] OP_RD_STAT = 8'h05;
   localparam logic [7:0] OP_WR_STAT = 8'h01;
   localparam logic [7:0] OP_READ    = 8'h03;
   localparam logic [7:0] OP_WRITE   = 8'h02;

   typedef enum logic [2:0] {
      PH_OPCODE,
      PH_RD_ADDR,
      PH_RD_DATA,
      PH_STATUS,
      PH_WR_ADDR,
      PH_WR_DATA,
      PH_WRSR_DATA,
      PH_IGNORE
   } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level
);
   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("spi_pin_sync: STAGES must be at least 1");
      end else if (STAGES == 1) begin : g_single
         logic q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= RESET_VAL;
            else        q <= din;
         end
         assign level = q;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], din};
         end
         assign level = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic sck_lvl,
   input  logic hold_lvl,
   output logic held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             held <= 1'b0;
      else if (!active)                       held <= 1'b0;
      else if (!held && !hold_lvl && sck_lvl) held <= 1'b1;
      else if (held && hold_lvl && sck_lvl)   held <= 1'b0;
   end
endmodule

// File: rtl/eeprom_page_buffer.sv
module eeprom_page_buffer #(
   parameter int PAGE_BYTES = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear,
   input  logic                          wr,
   input  logic [$clog2(PAGE_BYTES)-1:0] lane,
   input  logic [7:0]                    wdata,
   output logic [PAGE_BYTES-1:0]         mask,
   output logic [PAGE_BYTES*8-1:0]       data
);
   localparam int LW = $clog2(PAGE_BYTES);

   generate
      for (genvar l = 0; l < PAGE_BYTES; l++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mask[l]        <= 1'b0;
               data[l*8 +: 8] <= 8'h00;
            end else if (clear) begin
               mask[l] <= 1'b0;
            end else if (wr && lane == LW'(l)) begin
               mask[l]        <= 1'b1;
               data[l*8 +: 8] <= wdata;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    apply,
   input  logic [ADDR_W-1:0]       base,
   input  logic [PAGE_BYTES-1:0]   mask,
   input  logic [PAGE_BYTES*8-1:0] data,
   input  logic [ADDR_W-1:0]       rd_addr,
   output logic [7:0]              rd_data
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int LW    = $clog2(PAGE_BYTES);

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
      end else if (apply) begin
         for (int l = 0; l < PAGE_BYTES; l++) begin
            if (mask[l]) cells[{base[ADDR_W-1:LW], LW'(l)}] <= data[l*8 +: 8];
         end
      end
   end

   assign rd_data = cells[rd_addr];
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
   import spi_eeprom_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int PAGE_BYTES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    sck,
   input  logic                    mosi,
   input  logic                    hold_n,
   output logic                    miso,
   output logic                    miso_oe,
   input  logic                    nv_busy,
   input  logic [1:0]              prot_level,
   input  logic                    commit_done,
   output logic                    commit_req,
   output logic                    commit_is_status,
   output logic [ADDR_W-1:0]       commit_base,
   output logic [PAGE_BYTES-1:0]   commit_mask,
   output logic [PAGE_BYTES*8-1:0] commit_data
);
   localparam int                LW       = $clog2(PAGE_BYTES);
   localparam logic [ADDR_W-1:0] ADDR_ONE = 1;
   localparam logic [LW-1:0]     LANE_ONE = 1;

   generate
      if (ADDR_W < 2 || ADDR_W > 8) begin : g_bad_addr
         $error("spi_eeprom_engine: ADDR_W must lie in 2..8");
      end
      if (PAGE_BYTES < 2 || (1 << LW) != PAGE_BYTES || PAGE_BYTES >= (1 << ADDR_W)) begin : g_bad_page
         $error("spi_eeprom_engine: PAGE_BYTES must be a power of two, at least 2, below the array size");
      end
   endgenerate

   // pin synchronizers
   logic cs_lvl, sck_lvl, mosi_lvl, hold_lvl;
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_cs
      (.clk(clk), .rst_n(rst_n), .din(cs_n),   .level(cs_lvl));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_sck
      (.clk(clk), .rst_n(rst_n), .din(sck),    .level(sck_lvl));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sync_mosi
      (.clk(clk), .rst_n(rst_n), .din(mosi),   .level(mosi_lvl));
   spi_pin_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_hold
      (.clk(clk), .rst_n(rst_n), .din(hold_n), .level(hold_lvl));

   // edge detection, arming and selection
   logic cs_prev, sck_prev, armed, active, held;
   logic cs_rise_e, cs_fall_e, adv_fall, adv_rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b0;
         sck_prev <= 1'b0;
         armed    <= 1'b0;
         active   <= 1'b0;
      end else begin
         cs_prev  <= cs_lvl;
         sck_prev <= sck_lvl;
         if (cs_lvl) armed <= 1'b1;
         if (cs_rise_e)              active <= 1'b0;
         else if (cs_fall_e && armed) active <= 1'b1;
      end
   end

   assign cs_rise_e = !cs_prev && cs_lvl;
   assign cs_fall_e = cs_prev && !cs_lvl;

   spi_hold_gate u_hold (
      .clk(clk), .rst_n(rst_n), .active(active),
      .sck_lvl(sck_lvl), .hold_lvl(hold_lvl), .held(held)
   );

   assign adv_fall = active && !held && sck_prev && !sck_lvl;
   assign adv_rise = active && !held && !sck_prev && sck_lvl;

   // serial state
   phase_e            phase;
   logic [2:0]        bitcnt;
   logic [7:0]        rx, tx, byte_in, status_byte, wrsr_byte, rd_data;
   logic              so_q, wen_latch, wrsr_got, byte_done, commit_ok;
   logic [ADDR_W-1:0] addr, rd_addr;
   logic [PAGE_BYTES-1:0]   pb_mask;
   logic [PAGE_BYTES*8-1:0] pb_data;

   assign byte_in     = {rx[6:0], mosi_lvl};
   assign byte_done   = adv_fall && bitcnt == 3'd7;
   assign status_byte = nv_busy ? 8'hFF : {4'b0000, prot_level, wen_latch, 1'b0};
   assign rd_addr     = (phase == PH_RD_ADDR) ? byte_in[ADDR_W-1:0] : addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPCODE;
         bitcnt    <= 3'd0;
         rx        <= 8'h00;
         tx        <= 8'h00;
         so_q      <= 1'b0;
         addr      <= '0;
         wen_latch <= 1'b0;
         wrsr_byte <= 8'h00;
         wrsr_got  <= 1'b0;
      end else begin
         if (cs_rise_e || (cs_fall_e && armed)) begin
            phase    <= PH_OPCODE;
            bitcnt   <= 3'd0;
            tx       <= 8'h00;
            so_q     <= 1'b0;
            wrsr_got <= 1'b0;
         end else if (adv_fall) begin
            rx     <= byte_in;
            bitcnt <= bitcnt + 3'd1;
            if (byte_done) begin
               case (phase)
                  PH_OPCODE: begin
                     case (byte_in)
                        OP_RD_STAT: begin phase <= PH_STATUS; tx <= status_byte; end
                        OP_SET_WEN: begin phase <= PH_IGNORE; if (!nv_busy) wen_latch <= 1'b1; end
                        OP_CLR_WEN: begin phase <= PH_IGNORE; if (!nv_busy) wen_latch <= 1'b0; end
                        OP_WR_STAT: phase <= nv_busy ? PH_IGNORE : PH_WRSR_DATA;
                        OP_READ:    phase <= nv_busy ? PH_IGNORE : PH_RD_ADDR;
                        OP_WRITE:   phase <= nv_busy ? PH_IGNORE : PH_WR_ADDR;
                        default:    phase <= PH_IGNORE;
                     endcase
                  end
                  PH_RD_ADDR: begin
                     addr  <= byte_in[ADDR_W-1:0] + ADDR_ONE;
                     tx    <= rd_data;
                     phase <= PH_RD_DATA;
                  end
                  PH_RD_DATA: begin
                     addr <= addr + ADDR_ONE;
                     tx   <= rd_data;
                  end
                  PH_STATUS:  tx <= status_byte;
                  PH_WR_ADDR: begin
                     addr  <= byte_in[ADDR_W-1:0];
                     phase <= PH_WR_DATA;
                  end
                  PH_WR_DATA: addr <= {addr[ADDR_W-1:LW], addr[LW-1:0] + LANE_ONE};
                  PH_WRSR_DATA: begin
                     wrsr_byte <= byte_in;
                     wrsr_got  <= 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (adv_rise) begin
            so_q <= tx[7];
            tx   <= {tx[6:0], 1'b0};
         end
         if (commit_done) wen_latch <= 1'b0;
      end
   end

   // page collection
   eeprom_page_buffer #(.PAGE_BYTES(PAGE_BYTES)) u_page (
      .clk(clk), .rst_n(rst_n),
      .clear(byte_done && phase == PH_OPCODE),
      .wr(byte_done && phase == PH_WR_DATA),
      .lane(addr[LW-1:0]), .wdata(byte_in),
      .mask(pb_mask), .data(pb_data)
   );

   // commit on a legal chip-select release
   assign commit_ok = cs_rise_e && active && wen_latch && bitcnt == 3'd0 &&
                      ((phase == PH_WR_DATA && |pb_mask) ||
                       (phase == PH_WRSR_DATA && wrsr_got));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_req       <= 1'b0;
         commit_is_status <= 1'b0;
         commit_base      <= '0;
         commit_mask      <= '0;
         commit_data      <= '0;
      end else begin
         commit_req <= commit_ok;
         if (commit_ok) begin
            if (phase == PH_WRSR_DATA) begin
               commit_is_status <= 1'b1;
               commit_base      <= '0;
               commit_mask      <= {{(PAGE_BYTES-1){1'b0}}, 1'b1};
               commit_data      <= {{((PAGE_BYTES-1)*8){1'b0}}, wrsr_byte};
            end else begin
               commit_is_status <= 1'b0;
               commit_base      <= {addr[ADDR_W-1:LW], {LW{1'b0}}};
               commit_mask      <= pb_mask;
               commit_data      <= pb_data;
            end
         end
      end
   end

   eeprom_cell_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_cells (
      .clk(clk), .rst_n(rst_n),
      .apply(commit_done && !commit_is_status),
      .base(commit_base), .mask(commit_mask), .data(commit_data),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   assign miso    = so_q;
   assign miso_oe = active && !held;
endmodule

// File: rtl/spi_eeprom_engine_chk.sv
module spi_eeprom_engine_chk #(
   parameter int ADDR_W      = 8,
   parameter int PAGE_BYTES  = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cs_n,
   input logic                  miso,
   input logic                  miso_oe,
   input logic                  nv_busy,
   input logic                  held,
   input logic                  commit_req,
   input logic                  commit_is_status,
   input logic [ADDR_W-1:0]     commit_base,
   input logic [PAGE_BYTES-1:0] commit_mask
);
   localparam int LW    = $clog2(PAGE_BYTES);
   localparam int LIMIT = SYNC_STAGES + 2;

   int unsigned cs_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cs_hi_cnt <= 0;
      else if (!cs_n)          cs_hi_cnt <= 0;
      else if (cs_hi_cnt < 64) cs_hi_cnt <= cs_hi_cnt + 1;
   end

   // R10
   oe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hi_cnt >= LIMIT) |-> !miso_oe);

   // R6
   commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |=> !commit_req);

   // R6
   commit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> commit_mask != '0);

   // R5
   commit_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && !commit_is_status) |-> commit_base[LW-1:0] == '0);

   // R7
   status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_req && commit_is_status) |-> $countones(commit_mask) == 1 && commit_mask[0]);

   // R8
   commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_req |-> !nv_busy);

   // R9
   hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && $past(held)) |-> ($stable(miso) && !miso_oe));
endmodule

bind spi_eeprom_engine spi_eeprom_engine_chk #(
   .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
   .nv_busy(nv_busy), .held(held), .commit_req(commit_req),
   .commit_is_status(commit_is_status), .commit_base(commit_base),
   .commit_mask(commit_mask)
);

// File: tb/test_spi_eeprom_engine.sv
module test_spi_eeprom_engine;
   localparam int HALF = 10;
   localparam logic [7:0] C_SET = 8'h06, C_CLR = 8'h04, C_RDS = 8'h05,
                          C_WRS = 8'h01, C_RD  = 8'h03, C_WR  = 8'h02;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b0, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
   logic nv_busy = 1'b0, commit_done = 1'b0;
   logic [1:0] prot_level = 2'b00;
   logic miso, miso_oe, commit_req, commit_is_status;
   logic [7:0]  commit_base;
   logic [3:0]  commit_mask;
   logic [31:0] commit_data;

   int n_chk = 0, n_fail = 0, n_commit = 0;
   logic cap_status;
   logic [7:0]  cap_base;
   logic [3:0]  cap_mask;
   logic [31:0] cap_data;

   always #2 clk = ~clk;

   spi_eeprom_engine i_spi_eeprom_engine (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
      .hold_n(hold_n), .miso(miso), .miso_oe(miso_oe), .nv_busy(nv_busy),
      .prot_level(prot_level), .commit_done(commit_done),
      .commit_req(commit_req), .commit_is_status(commit_is_status),
      .commit_base(commit_base), .commit_mask(commit_mask),
      .commit_data(commit_data)
   );

   always @(negedge clk) begin
      if (rst_n && commit_req) begin
         n_commit   <= n_commit + 1;
         cap_status <= commit_is_status;
         cap_base   <= commit_base;
         cap_mask   <= commit_mask;
         cap_data   <= commit_data;
      end
   end

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic select_dev();
      cs_n = 1'b0; wait_clk(HALF);
   endtask

   task automatic release_dev();
      cs_n = 1'b1; wait_clk(HALF);
   endtask

   task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = tx[i]; sck = 1'b1; wait_clk(HALF);
         rx[i] = miso;
         sck = 1'b0; wait_clk(HALF);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      xfer_bits(tx, 8, rx);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      select_dev(); xfer(op, r); release_dev();
   endtask

   task automatic rd_status(output logic [7:0] s);
      logic [7:0] r;
      select_dev(); xfer(C_RDS, r); xfer(8'h00, s); release_dev();
   endtask

   task automatic wr_bytes(input logic [7:0] a, input logic [7:0] d [5], input int n);
      logic [7:0] r;
      select_dev(); xfer(C_WR, r); xfer(a, r);
      for (int i = 0; i < n; i++) xfer(d[i], r);
      release_dev();
   endtask

   task automatic rd_bytes(input logic [7:0] a, input int n, output logic [7:0] q [4]);
      logic [7:0] r;
      select_dev(); xfer(C_RD, r); xfer(a, r);
      for (int i = 0; i < n; i++) xfer(8'h00, q[i]);
      release_dev();
   endtask

   task automatic busy_off();
      wait_clk(2); commit_done = 1'b1; wait_clk(1);
      commit_done = 1'b0; nv_busy = 1'b0;
      if (cap_status) prot_level = cap_data[3:2];
      wait_clk(2);
   endtask

   task automatic t_reset_arm();
      logic [7:0] r, s;
      wait_clk(5); rst_n = 1'b1; wait_clk(10);
      check("R10 oe low after reset", {31'd0, miso_oe}, 32'd0);
      xfer(C_SET, r);
      check("R1 oe low before arming", {31'd0, miso_oe}, 32'd0);
      release_dev();
      rd_status(s);
      check("R1 command before arming ignored", {24'd0, s}, 32'h00);
      check("R10 oe low when deselected", {31'd0, miso_oe}, 32'd0);
   endtask

   task automatic t_latch();
      logic [7:0] r, s;
      cmd1(C_SET); rd_status(s);
      check("R2 set latch", {24'd0, s}, 32'h02);
      cmd1(C_CLR); rd_status(s);
      check("R2 clear latch", {24'd0, s}, 32'h00);
      select_dev(); xfer_bits(8'h00, 4, r); release_dev();
      cmd1(C_SET); rd_status(s);
      check("R12 partial command dropped", {24'd0, s}, 32'h02);
   endtask

   task automatic t_page_write();
      logic [7:0] d [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h00};
      logic [7:0] q [4];
      logic [7:0] s;
      int c0 = n_commit;
      wr_bytes(8'h01, d, 4);
      check("R6 page commit raised", n_commit, c0 + 1);
      check("R5 base", {24'd0, cap_base}, 32'h00);
      check("R5 mask", {28'd0, cap_mask}, 32'hF);
      check("R5 data lanes", cap_data, 32'h33221144);
      nv_busy = 1'b1;
      rd_status(s);
      check("R3 status while busy", {24'd0, s}, 32'hFF);
      busy_off();
      rd_status(s);
      check("R11 latch cleared on done", {24'd0, s}, 32'h00);
      rd_bytes(8'h00, 4, q);
      check("R11 R4 byte0", {24'd0, q[0]}, 32'h44);
      check("R4 byte1", {24'd0, q[1]}, 32'h11);
      check("R4 byte3", {24'd0, q[3]}, 32'h33);
   endtask

   task automatic t_page_wrap();
      logic [7:0] d [5] = '{8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
      logic [7:0] q [4];
      cmd1(C_SET);
      wr_bytes(8'h82, d, 5);
      check("R5 wrap base", {24'd0, cap_base}, 32'h80);
      check("R5 wrap data", cap_data, 32'hA2A5A4A3);
      nv_busy = 1'b1; busy_off();
      rd_bytes(8'h80, 4, q);
      check("R5 wrapped page readback", {q[0], q[1], q[2], q[3]}, 32'hA3A4A5A2);
   endtask

   task automatic t_discard();
      logic [7:0] r, s;
      logic [7:0] d [5] = '{8'h5A, 8'h00, 8'h00, 8'h00, 8'h00};
      logic [7:0] q [4];
      int c0;
      cmd1(C_SET);
      c0 = n_commit;
      select_dev(); xfer(C_WR, r); xfer(8'h10, r); xfer(8'h5A, r);
      xfer_bits(8'hFF, 3, r); release_dev();
      check("R6 release mid byte discards", n_commit, c0);
      select_dev(); xfer(C_WR, r); xfer(8'h10, r); release_dev();
      check("R6 no data byte discards", n_commit, c0);
      rd_status(s);
      check("R6 latch kept after discard", {24'd0, s}, 32'h02);
      cmd1(C_CLR);
      wr_bytes(8'h10, d, 1);
      check("R6 latch clear blocks commit", n_commit, c0);
      rd_bytes(8'h10, 1, q);
      check("R6 cell untouched", {24'd0, q[0]}, 32'hFF);
   endtask

   task automatic t_single();
      logic [7:0] d [5] = '{8'h5A, 8'h00, 8'h00, 8'h00, 8'h00};
      logic [7:0] q [4];
      cmd1(C_SET);
      wr_bytes(8'h10, d, 1);
      check("R5 single mask", {28'd0, cap_mask}, 32'h1);
      check("R5 single base", {24'd0, cap_base}, 32'h10);
      nv_busy = 1'b1; busy_off();
      rd_bytes(8'h0F, 3, q);
      check("R11 masked write only", {8'd0, q[0], q[1], q[2]}, 32'h00FF5AFF);
   endtask

   task automatic t_read_wrap();
      logic [7:0] q [4];
      rd_bytes(8'hFE, 3, q);
      check("R4 wrap to zero", {8'd0, q[0], q[1], q[2]}, 32'h00FFFF44);
   endtask

   task automatic t_status_write();
      logic [7:0] r, s;
      int c0;
      cmd1(C_SET);
      c0 = n_commit;
      select_dev(); xfer(C_WRS, r); xfer(8'h0C, r); release_dev();
      check("R7 status commit", n_commit, c0 + 1);
      check("R7 status kind", {31'd0, cap_status}, 32'd1);
      check("R7 status mask", {28'd0, cap_mask}, 32'h1);
      check("R7 status byte", {24'd0, cap_data[7:0]}, 32'h0C);
      nv_busy = 1'b1;
      rd_status(s);
      check("R3 busy reads all ones", {24'd0, s}, 32'hFF);
      select_dev(); xfer(C_RD, r); xfer(8'h00, r); xfer(8'h00, s); release_dev();
      check("R8 read ignored while busy", {24'd0, s}, 32'h00);
      select_dev(); xfer(C_WR, r); xfer(8'h20, r); xfer(8'h77, r); release_dev();
      check("R8 write ignored while busy", n_commit, c0 + 1);
      busy_off();
      rd_status(s);
      check("R3 protection bits", {24'd0, s}, 32'h0C);
      cmd1(C_SET); rd_status(s);
      check("R3 protection and latch", {24'd0, s}, 32'h0E);
      cmd1(C_CLR);
   endtask

   task automatic t_hold();
      logic [7:0] r, b0, b1;
      select_dev(); xfer(C_RD, r); xfer(8'h00, r);
      b0 = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         mosi = 1'b0; sck = 1'b1; wait_clk(HALF);
         b0[i] = miso;
         if (i == 4) begin
            hold_n = 1'b0; wait_clk(HALF);
            check("R9 oe low while paused", {31'd0, miso_oe}, 32'd0);
            sck = 1'b0; wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
            hold_n = 1'b1; wait_clk(HALF);
            check("R10 oe back after pause", {31'd0, miso_oe}, 32'd1);
         end
         sck = 1'b0; wait_clk(HALF);
      end
      xfer(8'h00, b1);
      release_dev();
      check("R9 byte across pause", {24'd0, b0}, 32'h44);
      check("R9 next byte after pause", {24'd0, b1}, 32'h11);
   endtask

   initial begin
      t_reset_arm();
      t_latch();
      cmd1(C_CLR);
      cmd1(C_SET);
      t_page_write();
      t_page_wrap();
      t_discard();
      t_single();
      t_read_wrap();
      t_status_write();
      t_hold();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule